// File: doc/BRIEF.md
# Virtual-to-Physical Address Translation Unit

This block converts 14-bit virtual addresses into 12-bit physical addresses for a small paged memory system with 64-byte pages. A requester presents a virtual address together with an access kind (read or write) and a privilege level (user or supervisor). The unit first compares the virtual page number against a 16-entry, 4-set by 4-way translation cache. On a hit the answer is formed locally. On a miss it fetches one page table entry from memory through a request/response port, at the page-table base plus the virtual page number, installs a valid entry in the cache and then answers.

Every answer carries a 2-bit status. An entry whose valid bit is clear yields a page fault. An entry that denies the access yields a protection fault. Either fault returns a zero physical address so that software can repair the table and retry. A flush input drops every cached translation in one cycle, for use when the page-table base changes. Only one request is in flight at a time.

Top module: `xlat_unit`

## Requirements
- R1: The low 6 bits of the virtual address pass unchanged into the physical address; a successful response has rsp_paddr = {PPN, vaddr[5:0]}.
- R2: The cache holds 4 sets of 4 ways; the set is VPN[1:0] and the tag is VPN[7:2], where VPN = vaddr[13:6]. A hit answers with no memory read.
- R3: A miss issues exactly one single-cycle memory read at mem_req_addr = ptbr + VPN (12-bit sum).
- R4: A page table entry holds the PPN in bits 5:0, the valid bit in bit 6, the supervisor-only bit in bit 7, the read-allowed bit in bit 8 and the write-allowed bit in bit 9. A fetched entry with bit 6 clear gives status 1 (page fault) with rsp_paddr = 0 and is not cached, so a retry after the table is fixed translates normally.
- R5: For a valid entry, a user access to a supervisor-only page, a write to a page with bit 9 clear, or a read to a page with bit 8 clear gives status 2 (protection fault) with rsp_paddr = 0. This check applies to hits and walks alike.
- R6: A walk that returns a valid entry installs it in its set, in the lowest-numbered invalid way, or else in the way named by that set's 2-bit round-robin pointer, which then advances by one. An entry that leads to a protection fault is cached too.
- R7: req_ready is high in idle and low from the cycle after a request is accepted until the cycle in which its response appears.
- R8: A high flush invalidates every cached entry at the next clock edge. When flush coincides with the edge that would install a walked entry, the flush wins and nothing stays cached.
- R9: Status 0 means success, 1 page fault and 2 protection fault; 3 never appears. rsp_valid is a one-cycle pulse, one per accepted request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all cached translations |
| ptbr | input | 12 | Page-table base address in memory |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit can accept a request |
| req_vaddr | input | 14 | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_user | input | 1 | 1 = user mode, 0 = supervisor mode |
| rsp_valid | output | 1 | Response pulse |
| rsp_paddr | output | 12 | Physical address, zero on fault |
| rsp_status | output | 2 | 0 ok, 1 page fault, 2 protection fault |
| mem_req_valid | output | 1 | Page table read request pulse |
| mem_req_addr | output | 12 | Address of the page table entry |
| mem_rsp_valid | input | 1 | Page table read data present |
| mem_rsp_data | input | 10 | Page table entry |

## Verification
The two functions that can land in the same clock edge are the flush of the translation cache and the installation of an entry fetched by a walk. The bench's memory model raises flush in the very cycle it returns the entry, so both act on one edge. The response must still carry the walked translation. A repeat of the same address must then walk again, which shows at the ports as a new memory read, while the bench's own cache model applies the rule that the flush wins.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int VA_W   = 14;
    localparam int PA_W   = 12;
    localparam int OFF_W  = 6;
    localparam int SETS   = 4;
    localparam int WAYS   = 4;
    localparam int MEM_AW = 12;

    localparam int VPN_W  = VA_W - OFF_W;
    localparam int PPN_W  = PA_W - OFF_W;
    localparam int SET_W  = $clog2(SETS);
    localparam int WAY_W  = $clog2(WAYS);
    localparam int TAG_W  = VPN_W - SET_W;

    // ppn in the low bits, then valid, supervisor-only, read, write
    typedef struct packed {
        logic             wr_ok;
        logic             rd_ok;
        logic             sup_only;
        logic             present;
        logic [PPN_W-1:0] ppn;
    } pte_t;

    localparam int PTE_W = $bits(pte_t);

    typedef enum logic [1:0] {
        XS_OK    = 2'd0,
        XS_PGFLT = 2'd1,
        XS_PROT  = 2'd2
    } xstat_e;

    function automatic logic access_denied(pte_t p, logic is_wr, logic is_user);
        return (is_user & p.sup_only) | (is_wr & ~p.wr_ok) | (~is_wr & ~p.rd_ok);
    endfunction

    function automatic xstat_e judge(pte_t p, logic is_wr, logic is_user);
        if (!p.present)                    return XS_PGFLT;
        if (access_denied(p, is_wr, is_user)) return XS_PROT;
        return XS_OK;
    endfunction

endpackage

// File: rtl/xlat_tlb.sv
module xlat_tlb
    import xlat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic [VPN_W-1:0] vpn,
    output logic             hit,
    output pte_t             hit_pte,
    input  logic             fill_en,
    input  pte_t             fill_pte
);
    localparam int NENT = SETS * WAYS;

    logic             vld_q [SETS][WAYS];
    logic [TAG_W-1:0] tag_q [SETS][WAYS];
    pte_t             pte_q [SETS][WAYS];
    logic [WAY_W-1:0] rr_q  [SETS];

    logic [SET_W-1:0] set_idx;
    logic [TAG_W-1:0] tag_in;
    logic [WAYS-1:0]  hit_vec;
    logic [NENT-1:0]  vld_flat;
    logic             has_free;
    logic [WAY_W-1:0] victim;

    assign set_idx = vpn[SET_W-1:0];
    assign tag_in  = vpn[VPN_W-1:SET_W];

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = vld_q[set_idx][w] && (tag_q[set_idx][w] == tag_in);
    end

    for (genvar s = 0; s < SETS; s++) begin : g_fs
        for (genvar w = 0; w < WAYS; w++) begin : g_fw
            assign vld_flat[s*WAYS + w] = vld_q[s][w];
        end
    end

    assign hit = |hit_vec;

    always_comb begin
        hit_pte = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) hit_pte = pte_q[set_idx][w];
        end
    end

    // lowest invalid way wins, else the set's round-robin pointer
    always_comb begin
        has_free = 1'b0;
        victim   = rr_q[set_idx];
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!vld_q[set_idx][w]) begin
                has_free = 1'b1;
                victim   = WAY_W'(w);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                rr_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) vld_q[s][w] <= 1'b0;
            end
        end else if (flush) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++) vld_q[s][w] <= 1'b0;
        end else if (fill_en) begin
            vld_q[set_idx][victim] <= 1'b1;
            if (!has_free) rr_q[set_idx] <= rr_q[set_idx] + WAY_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[set_idx][victim] <= tag_in;
            pte_q[set_idx][victim] <= fill_pte;
        end
    end

    assert_flush_clears_R8: assert property (@(posedge clk) disable iff (rst)
        flush |=> ($countones(vld_flat) == 0));

    assert_single_way_hit_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

    assert_fill_only_on_miss_R6: assert property (@(posedge clk) disable iff (rst)
        fill_en |-> !hit);

endmodule

// File: rtl/xlat_walk.sv
module xlat_walk
    import xlat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic              req_write,
    input  logic              req_user,
    input  logic [MEM_AW-1:0] ptbr,
    output logic [VPN_W-1:0]  tlb_vpn,
    input  logic              tlb_hit,
    input  pte_t              tlb_pte,
    output logic              fill_en,
    output pte_t              fill_pte,
    output logic              mem_req_valid,
    output logic [MEM_AW-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [PTE_W-1:0]  mem_rsp_data,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic [1:0]        rsp_status
);
    typedef enum logic [1:0] { W_IDLE, W_LOOK, W_WAIT } wstate_e;

    wstate_e          state_q;
    logic [VA_W-1:0]  va_q;
    logic             wr_q;
    logic             usr_q;

    pte_t             walk_pte;
    pte_t             use_pte;
    xstat_e           verdict;
    logic [PA_W-1:0]  pa_next;

    assign walk_pte  = pte_t'(mem_rsp_data);
    assign tlb_vpn   = va_q[VA_W-1:OFF_W];
    assign req_ready = (state_q == W_IDLE);
    assign fill_en   = (state_q == W_WAIT) && mem_rsp_valid && walk_pte.present;
    assign fill_pte  = walk_pte;

    always_comb begin
        use_pte = (state_q == W_LOOK) ? tlb_pte : walk_pte;
        verdict = judge(use_pte, wr_q, usr_q);
        pa_next = (verdict == XS_OK) ? {use_pte.ppn, va_q[OFF_W-1:0]} : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q       <= W_IDLE;
            va_q          <= '0;
            wr_q          <= 1'b0;
            usr_q         <= 1'b0;
            rsp_valid     <= 1'b0;
            rsp_paddr     <= '0;
            rsp_status    <= XS_OK;
            mem_req_valid <= 1'b0;
            mem_req_addr  <= '0;
        end else begin
            rsp_valid     <= 1'b0;
            mem_req_valid <= 1'b0;
            unique case (state_q)
                W_IDLE: if (req_valid) begin
                    va_q    <= req_vaddr;
                    wr_q    <= req_write;
                    usr_q   <= req_user;
                    state_q <= W_LOOK;
                end
                W_LOOK: if (tlb_hit) begin
                    rsp_valid  <= 1'b1;
                    rsp_paddr  <= pa_next;
                    rsp_status <= verdict;
                    state_q    <= W_IDLE;
                end else begin
                    mem_req_valid <= 1'b1;
                    mem_req_addr  <= ptbr + MEM_AW'(tlb_vpn);
                    state_q       <= W_WAIT;
                end
                W_WAIT: if (mem_rsp_valid) begin
                    rsp_valid  <= 1'b1;
                    rsp_paddr  <= pa_next;
                    rsp_status <= verdict;
                    state_q    <= W_IDLE;
                end
                default: state_q <= W_IDLE;
            endcase
        end
    end

    assert_ready_drops_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    assert_hit_no_walk_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == W_LOOK && tlb_hit) |=> !mem_req_valid);

    assert_walk_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |=> !mem_req_valid);

    assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    assert_status_legal_R9: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_status != 2'd3));

    assert_fault_zero_pa_R4: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_status != 2'd0) |-> (rsp_paddr == '0));

endmodule

// File: rtl/xlat_unit.sv
module xlat_unit
    import xlat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic [MEM_AW-1:0] ptbr,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic              req_write,
    input  logic              req_user,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic [1:0]        rsp_status,
    output logic              mem_req_valid,
    output logic [MEM_AW-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [PTE_W-1:0]  mem_rsp_data
);
    logic [VPN_W-1:0] vpn;
    logic             hit;
    pte_t             hit_pte;
    logic             fill_en;
    pte_t             fill_pte;

    xlat_tlb i_tlb (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .vpn      (vpn),
        .hit      (hit),
        .hit_pte  (hit_pte),
        .fill_en  (fill_en),
        .fill_pte (fill_pte)
    );

    xlat_walk i_walk (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_vaddr     (req_vaddr),
        .req_write     (req_write),
        .req_user      (req_user),
        .ptbr          (ptbr),
        .tlb_vpn       (vpn),
        .tlb_hit       (hit),
        .tlb_pte       (hit_pte),
        .fill_en       (fill_en),
        .fill_pte      (fill_pte),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .rsp_valid     (rsp_valid),
        .rsp_paddr     (rsp_paddr),
        .rsp_status    (rsp_status)
    );

endmodule

// File: tb/test_xlat_unit.sv
`timescale 1ns/1ps
module test_xlat_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush = 1'b0;
    logic [11:0] ptbr = 12'h100;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [13:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        rsp_valid;
    logic [11:0] rsp_paddr;
    logic [1:0]  rsp_status;
    logic        mem_req_valid;
    logic [11:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [9:0]  mem_rsp_data = '0;

    int n_tests = 0;
    int n_fail  = 0;
    int n_reads = 0;
    logic [11:0] last_addr = '0;
    bit flush_with_rsp = 1'b0;

    logic [9:0] pt [256];
    bit         r_vld [4][4];
    logic [5:0] r_tag [4][4];
    logic [9:0] r_pte [4][4];
    int         r_rr  [4];

    always #5 clk = ~clk;

    xlat_unit i_xlat_unit (
        .clk(clk), .rst(rst), .flush(flush), .ptbr(ptbr),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_user(req_user),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_status(rsp_status),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    function automatic logic [9:0] mk(input logic [5:0] ppn, input bit v, s, r, w);
        return {w, r, s, v, ppn};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic ref_clear();
        for (int s = 0; s < 4; s++)
            for (int w = 0; w < 4; w++) r_vld[s][w] = 1'b0;
    endtask

    // memory model: two cycles of latency, optional flush on the data cycle
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req_valid) begin
                logic [11:0] a;
                bit fl;
                a = mem_req_addr;
                n_reads++;
                last_addr = a;
                repeat (2) @(negedge clk);
                fl = flush_with_rsp;
                mem_rsp_data  = pt[8'(a - ptbr)];
                mem_rsp_valid = 1'b1;
                if (fl) flush = 1'b1;
                @(negedge clk);
                mem_rsp_valid = 1'b0;
                if (fl) flush = 1'b0;
                flush_with_rsp = 1'b0;
            end
        end
    end

    task automatic ref_access(input logic [13:0] va, input bit wr, usr, fl,
                              output logic [1:0] est, output logic [11:0] epa, output int erd);
        logic [7:0] vpn;
        logic [1:0] s;
        logic [5:0] t;
        logic [9:0] p;
        int hw;
        int vw;
        vpn = va[13:6];
        s = vpn[1:0];
        t = vpn[7:2];
        hw = -1;
        for (int w = 0; w < 4; w++)
            if (r_vld[s][w] && r_tag[s][w] == t) hw = w;
        if (hw >= 0) begin
            p = r_pte[s][hw];
            erd = 0;
        end else begin
            p = pt[vpn];
            erd = 1;
            if (fl) ref_clear();
            else if (p[6]) begin
                vw = -1;
                for (int w = 3; w >= 0; w--) if (!r_vld[s][w]) vw = w;
                if (vw < 0) begin
                    vw = r_rr[s];
                    r_rr[s] = (r_rr[s] + 1) % 4;
                end
                r_vld[s][vw] = 1'b1;
                r_tag[s][vw] = t;
                r_pte[s][vw] = p;
            end
        end
        if (!p[6]) est = 2'd1;
        else if ((usr && p[7]) || (wr && !p[9]) || (!wr && !p[8])) est = 2'd2;
        else est = 2'd0;
        epa = (est == 2'd0) ? {p[5:0], va[5:0]} : 12'h000;
    endtask

    task automatic do_req(input logic [13:0] va, input bit wr, usr,
                          output logic [1:0] st, output logic [11:0] pa, output int rd,
                          output logic [11:0] addr, output bit busy_ok, output bit pulse_ok);
        int base;
        int t;
        base = n_reads;
        busy_ok = 1'b1;
        @(negedge clk);
        req_vaddr = va;
        req_write = wr;
        req_user  = usr;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        t = 0;
        while (!rsp_valid && t < 100) begin
            if (req_ready) busy_ok = 1'b0;
            @(negedge clk);
            t++;
        end
        st = rsp_status;
        pa = rsp_paddr;
        rd = n_reads - base;
        addr = last_addr;
        @(negedge clk);
        pulse_ok = !rsp_valid;
    endtask

    task automatic run(input logic [13:0] va, input bit wr, usr, fl, input string tag,
                       output logic [1:0] st, output logic [11:0] pa);
        logic [1:0] est;
        logic [11:0] epa;
        int erd;
        int rd;
        logic [11:0] addr;
        bit busy_ok;
        bit pulse_ok;
        ref_access(va, wr, usr, fl, est, epa, erd);
        flush_with_rsp = fl && (erd == 1);
        do_req(va, wr, usr, st, pa, rd, addr, busy_ok, pulse_ok);
        check({tag, " status"}, 32'(st), 32'(est));
        check({tag, " paddr"}, 32'(pa), 32'(epa));
        check("R2 R3 memory read count", 32'(rd), 32'(erd));
        if (erd == 1) check("R3 walk address", 32'(addr), 32'(ptbr + {4'h0, va[13:6]}));
        check("R7 ready low while busy", 32'(busy_ok), 32'd1);
        check("R9 single-cycle response", 32'(pulse_ok), 32'd1);
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        ref_clear();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [1:0] st;
        logic [11:0] pa;
        void'($urandom(32'd1234));
        for (int i = 0; i < 256; i++) pt[i] = 10'h000;
        ref_clear();
        for (int s = 0; s < 4; s++) r_rr[s] = 0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R7 reset ready", 32'(req_ready), 32'd1);
        check("R9 reset rsp_valid", 32'(rsp_valid), 32'd0);
        check("R3 reset mem_req_valid", 32'(mem_req_valid), 32'd0);

        // R1 R2: miss then hit on the same page
        pt[8'h0F] = mk(6'h0D, 1, 0, 1, 1);
        run(14'h03D4, 0, 1, 0, "R3 first walk", st, pa);
        check("R1 walked address 0x354", 32'(pa), 32'h354);
        run(14'h03D4, 0, 1, 0, "R2 hit", st, pa);
        check("R2 hit address 0x354", 32'(pa), 32'h354);

        pt[8'h00] = mk(6'h28, 1, 0, 1, 1);
        run(14'h0020, 0, 0, 0, "R1 offset pass-through", st, pa);
        check("R1 address 0xA20", 32'(pa), 32'hA20);

        // R4 page fault then retry
        run(14'h0B8F, 0, 0, 0, "R4 page fault", st, pa);
        check("R4 fault status", 32'(st), 32'd1);
        pt[8'h2E] = mk(6'h15, 1, 0, 1, 0);
        run(14'h0B8F, 0, 0, 0, "R4 retry", st, pa);
        check("R4 retry ok", 32'(st), 32'd0);

        // R5 protection
        pt[8'h11] = mk(6'h22, 1, 1, 1, 0);
        run(14'h0444, 0, 1, 0, "R5 user on supervisor page", st, pa);
        check("R5 user sup fault", 32'(st), 32'd2);
        run(14'h0444, 0, 0, 0, "R5 supervisor read on hit", st, pa);
        check("R5 supervisor ok", 32'(st), 32'd0);
        run(14'h0444, 1, 0, 0, "R5 write without permission", st, pa);
        check("R5 write fault", 32'(st), 32'd2);
        pt[8'h12] = mk(6'h05, 1, 0, 0, 1);
        run(14'h0487, 0, 0, 0, "R5 read without permission", st, pa);
        check("R5 read fault", 32'(st), 32'd2);

        // R6 replacement within set 2
        do_flush();
        for (int k = 0; k < 6; k++) pt[8'h02 + 8'(4*k)] = mk(6'(k + 1), 1, 0, 1, 1);
        for (int k = 0; k < 5; k++) run({8'h02 + 8'(4*k), 6'h01}, 0, 0, 0, "R6 fill", st, pa);
        run({8'h02, 6'h02}, 0, 0, 0, "R6 evicted way refetched", st, pa);
        run({8'h0A, 6'h03}, 0, 0, 0, "R6 survivor hits", st, pa);
        run({8'h16, 6'h04}, 0, 0, 0, "R6 round-robin victim", st, pa);
        run({8'h06, 6'h05}, 0, 0, 0, "R6 second victim refetched", st, pa);

        // R8 flush at idle and flush colliding with fill
        run(14'h03D4, 0, 1, 0, "R8 warm", st, pa);
        do_flush();
        run(14'h03D4, 0, 1, 0, "R8 after flush", st, pa);
        run(14'h0020, 0, 0, 1, "R8 flush with fill", st, pa);
        run(14'h0020, 0, 0, 0, "R8 nothing kept after collision", st, pa);

        // R3 new base register
        do_flush();
        ptbr = 12'h2A0;
        run(14'h0B8F, 0, 0, 0, "R3 new base", st, pa);
        ptbr = 12'h100;
        do_flush();

        // random traffic
        for (int n = 0; n < 400; n++) begin
            logic [7:0] vpn;
            bit fl;
            if ($urandom_range(0, 7) == 0) begin
                pt[8'($urandom_range(0, 23))] = mk(6'($urandom),
                    $urandom_range(0, 99) < 85, $urandom_range(0, 99) < 30,
                    $urandom_range(0, 99) < 80, $urandom_range(0, 99) < 60);
            end
            if ($urandom_range(0, 19) == 0) do_flush();
            fl = ($urandom_range(0, 19) == 0);
            vpn = 8'($urandom_range(0, 23));
            run({vpn, 6'($urandom)}, 1'($urandom), 1'($urandom), fl, "R9 random", st, pa);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule